// File: doc/BRIEF.md
# Error-Corrected Binary Sequencer

This block is a small control sequencer that keeps its state in the fewest flip-flops that binary encoding allows. The stored state word is widened with Hamming check bits and one overall parity bit. In every cycle the stored word is decoded, and any single flipped bit is repaired before the next-state logic sees it. The repaired state is then re-encoded and written back at the next clock edge, so the upset is scrubbed. A double-bit upset cannot be repaired. Neither can a word that decodes cleanly to a code outside the sequence. In either case the sequencer stops and raises a sticky flag, and a supervisor above it decides what to do.

The sequence steps through states 0 to NUM_STATES-1 and wraps back to 0. It moves one step per clock while the advance request is high. Each state drives its own strobe, decoded from the full state vector. A one-cycle pulse reports every single-bit repair. A test-only mask input XORs bits into the stored word so that upsets can be created on purpose.

Top module: `secded_seq`

## Requirements
- R1: With the default of six states, the state uses 3 bits and the stored word is 7 bits wide. Bit 0 is even parity over the whole word. Bits 1 to 6 hold Hamming positions 1 to 6. The check bits sit at positions 1, 2 and 4. The state bits sit at positions 3, 5 and 6, with the least significant state bit at position 3. The check bit at position 2^k makes even parity over every position whose index has bit k set.
- R2: After a synchronous reset (rst_n low at a clock edge) the state is 0. Only strobe 0 is high, and the corrected, uncorrectable and halted outputs are low.
- R3: A single flipped bit in the stored word does not change the state that the strobes show, nor the next state. The word is rewritten without the error at the next clock edge.
- R4: corrected_o is high for exactly the one cycle after the edge that repairs a single-bit error, and it is low otherwise.
- R5: While not halted, the state moves to (state+1) mod NUM_STATES at each edge where advance_i is high, and holds its value otherwise.
- R6: At most one strobe is high. Strobe i is high only when the decoded state equals i. No strobe is high while halted, while the stored word holds a double error, or while the state code is illegal.
- R7: A double-bit error in the stored word, seen at a clock edge while running, sets uncorrectable_o and halted_o at that edge. Both stay set, and the state stops advancing, until reset or clear.
- R8: A stored word that decodes to state code 6 or 7 (a legal codeword of an illegal state) halts the machine and sets uncorrectable_o, exactly as R7 does.
- R9: clear_err_i high at a clock edge releases the halt and the flag, and returns the machine to state 0 with a clean word.
- R10: A nonzero inject_mask_i at a clock edge XORs the mask into the stored word instead of the normal update, so the state does not advance at that edge. Reset and clear take priority over the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| advance_i | input | 1 | Request to step to the next state |
| clear_err_i | input | 1 | Releases the halt and flag, returns to state 0 |
| inject_mask_i | input | WORD_W | Test-only upset mask XORed into the stored word |
| state_strobe_o | output | NUM_STATES | One fully decoded strobe per state |
| corrected_o | output | 1 | One-cycle pulse per repaired single-bit error |
| uncorrectable_o | output | 1 | Sticky flag for a double error or an illegal state |
| halted_o | output | 1 | Sticky flag: the sequencer has stopped |

## Verification
A single upset that the logic missed would show on the strobes in the cycle right after the injection edge, as a strobe on the wrong state or as no strobe at all. A repair that never reached the register would show one edge later, as a second corrected pulse or as a sequence that goes astray. A wrong decision on a double error or an illegal code shows at the next edge, as halted_o staying low while the strobes keep moving. The bench follows every cycle with its own model and compares all outputs at each falling edge. Random advance, single-upset, double-upset, illegal-code and clear stimuli are mixed with directed cases for wrap-around, injection on an advance edge, and release from a halt.

// File: rtl/secded_seq_pkg.sv
// Package: shared sizing helpers for the error-corrected sequencer.
// Assumes data widths small enough that eight check bits always suffice.
package secded_seq_pkg;

    // Number of Hamming check bits p needed for dw data bits: 2^p >= dw+p+1.
    function automatic int hamming_checks(input int dw);
        int p;
        p = 1;
        for (int k = 0; k < 8; k++) begin
            if ((1 << p) < dw + p + 1) begin
                p = p + 1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/secded_seq_enc.sv
// Module: secded_seq_enc
// Builds an extended Hamming word from DATA_W data bits. Bit 0 of the word is
// overall even parity. Bit i (1..DATA_W+CHK_W) is Hamming position i, with
// check bits at the powers of two and data bits filling the other positions
// in ascending order. Assumes CHK_W is large enough for DATA_W.
module secded_seq_enc #(
    parameter int DATA_W = 3,
    parameter int CHK_W  = 3,
    localparam int POS_N  = DATA_W + CHK_W,
    localparam int WORD_W = POS_N + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);

    // Place data bits, compute the check bits, then the overall parity.
    always_comb begin
        logic [WORD_W-1:0] w;
        logic par;
        int di;
        w  = '0;
        di = 0;
        for (int pos = 1; pos <= POS_N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                w[pos] = data_i[di];
                di     = di + 1;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int pos = 1; pos <= POS_N; pos++) begin
                if ((((pos >> k) & 1) == 1) && (pos != (1 << k))) begin
                    par = par ^ w[pos];
                end
            end
            w[1 << k] = par;
        end
        w[0]   = ^w;
        word_o = w;
    end

endmodule

// File: rtl/secded_seq_dec.sv
// Module: secded_seq_dec
// Checks an extended Hamming word laid out as in secded_seq_enc. It repairs any
// single flipped bit and flags double errors. A syndrome that points past the
// last position counts as uncorrectable. Purely combinational.
module secded_seq_dec #(
    parameter int DATA_W = 3,
    parameter int CHK_W  = 3,
    localparam int POS_N  = DATA_W + CHK_W,
    localparam int WORD_W = POS_N + 1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              fatal_o
);

    logic [CHK_W-1:0]  syn;
    logic              odd;
    logic [WORD_W-1:0] fixed;

    // Syndrome and overall parity over the raw word.
    always_comb begin
        syn = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int pos = 1; pos <= POS_N; pos++) begin
                if (((pos >> k) & 1) == 1) begin
                    syn[k] = syn[k] ^ word_i[pos];
                end
            end
        end
        odd = ^word_i;
    end

    // Classify the error and flip the bit the syndrome points at.
    always_comb begin
        fixed    = word_i;
        single_o = 1'b0;
        fatal_o  = 1'b0;
        if (odd) begin
            if (int'(syn) <= POS_N) begin
                single_o = 1'b1;
                for (int pos = 0; pos <= POS_N; pos++) begin
                    if (pos == int'(syn)) begin
                        fixed[pos] = ~word_i[pos];
                    end
                end
            end else begin
                fatal_o = 1'b1;
            end
        end else if (syn != '0) begin
            fatal_o = 1'b1;
        end
    end

    // Pull the data bits back out of the non-power-of-two positions.
    always_comb begin
        int di;
        data_o = '0;
        di     = 0;
        for (int pos = 1; pos <= POS_N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[di] = fixed[pos];
                di         = di + 1;
            end
        end
    end

endmodule

// File: rtl/secded_seq_step.sv
// Module: secded_seq_step
// Next-state logic of the sequencer. It counts 0..NUM_STATES-1 with wrap while
// advance_i is high and holds otherwise. Assumes cur_i is a legal state; the
// parent blocks the update when it is not.
module secded_seq_step #(
    parameter int NUM_STATES = 6,
    parameter int STATE_W    = 3
) (
    input  logic [STATE_W-1:0] cur_i,
    input  logic               advance_i,
    output logic [STATE_W-1:0] nxt_o
);

    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_STATES - 1);

    // Wrap at the last state, otherwise increment or hold.
    always_comb begin
        if (!advance_i) begin
            nxt_o = cur_i;
        end else if (cur_i == LAST) begin
            nxt_o = '0;
        end else begin
            nxt_o = cur_i + 1'b1;
        end
    end

endmodule

// File: rtl/secded_seq_strobe.sv
// Module: secded_seq_strobe
// Fully decoded per-state strobes. Each strobe compares the whole state
// vector, so an illegal code drives no strobe. enable_i gates every strobe.
module secded_seq_strobe #(
    parameter int NUM_STATES = 6,
    parameter int STATE_W    = 3
) (
    input  logic [STATE_W-1:0]    state_i,
    input  logic                  enable_i,
    output logic [NUM_STATES-1:0] strobe_o
);

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_dec
        // Full-vector match for state i.
        assign strobe_o[i] = enable_i && (state_i == STATE_W'(i));
    end

endmodule

// File: rtl/secded_seq.sv
// Module: secded_seq (top)
// Binary-coded sequencer whose state register carries extended Hamming
// protection. The repaired state feeds the next-state logic and is re-encoded
// on every edge. Double errors and illegal codes halt the machine with a
// sticky flag. Assumes NUM_STATES >= 2. The all-zero word encodes state 0
// because the code is linear.
module secded_seq #(
    parameter int NUM_STATES = 6,
    localparam int STATE_W = $clog2(NUM_STATES),
    localparam int CHK_W   = secded_seq_pkg::hamming_checks(STATE_W),
    localparam int WORD_W  = STATE_W + CHK_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance_i,
    input  logic                  clear_err_i,
    input  logic [WORD_W-1:0]     inject_mask_i,
    output logic [NUM_STATES-1:0] state_strobe_o,
    output logic                  corrected_o,
    output logic                  uncorrectable_o,
    output logic                  halted_o
);

    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_STATES - 1);

    logic [WORD_W-1:0]  word_q;
    logic [WORD_W-1:0]  next_word;
    logic [STATE_W-1:0] fixed_state;
    logic [STATE_W-1:0] next_state;
    logic               err_single;
    logic               err_fatal;
    logic               legal;
    logic               halted_q;
    logic               uncorr_q;
    logic               corr_q;
    logic               injecting;

    secded_seq_dec #(.DATA_W(STATE_W), .CHK_W(CHK_W)) u_dec (
        .word_i   (word_q),
        .data_o   (fixed_state),
        .single_o (err_single),
        .fatal_o  (err_fatal)
    );

    secded_seq_step #(.NUM_STATES(NUM_STATES), .STATE_W(STATE_W)) u_step (
        .cur_i     (fixed_state),
        .advance_i (advance_i),
        .nxt_o     (next_state)
    );

    secded_seq_enc #(.DATA_W(STATE_W), .CHK_W(CHK_W)) u_enc (
        .data_i (next_state),
        .word_o (next_word)
    );

    secded_seq_strobe #(.NUM_STATES(NUM_STATES), .STATE_W(STATE_W)) u_strobe (
        .state_i  (fixed_state),
        .enable_i (!halted_q && !err_fatal),
        .strobe_o (state_strobe_o)
    );

    // Legality of the repaired state code.
    assign legal     = (fixed_state <= LAST);
    assign injecting = (inject_mask_i != '0);

    // State word, halt, flag and repair pulse; priority reset > clear > inject.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_err_i) begin
            word_q   <= '0;
            halted_q <= 1'b0;
            uncorr_q <= 1'b0;
            corr_q   <= 1'b0;
        end else if (injecting) begin
            word_q <= word_q ^ inject_mask_i;
            corr_q <= 1'b0;
        end else if (halted_q) begin
            corr_q <= 1'b0;
        end else if (err_fatal || !legal) begin
            halted_q <= 1'b1;
            uncorr_q <= 1'b1;
            corr_q   <= 1'b0;
        end else begin
            word_q <= next_word;
            corr_q <= err_single;
        end
    end

    assign corrected_o     = corr_q;
    assign uncorrectable_o = uncorr_q;
    assign halted_o        = halted_q;

    // A repaired word is clean one edge later (R3).
    p_scrub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single && !halted_q && legal && !clear_err_i && !injecting)
        |=> (!err_single && !err_fatal));

    // The repair edge raises the pulse (R4).
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single && !halted_q && legal && !clear_err_i && !injecting)
        |=> corrected_o);

    // Hold without an advance request (R5).
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !err_fatal && legal && !advance_i && !clear_err_i && !injecting)
        |=> $stable(fixed_state));

    // Wrap from the last state to 0 (R5).
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !err_fatal && fixed_state == LAST && advance_i
         && !clear_err_i && !injecting)
        |=> (fixed_state == '0));

    // Strobes are mutually exclusive and quiet while halted (R6).
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_strobe_o));
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> (state_strobe_o == '0));

    // Halt and flag are sticky until clear (R7).
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !clear_err_i) |=> (halted_q && uncorr_q));

    // A fatal error while running halts at the next edge (R7).
    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_fatal && !clear_err_i && !injecting) |=> halted_q);

    // Clear returns to a clean state 0 (R9).
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_err_i |=> (!halted_q && !uncorr_q && fixed_state == '0 && !err_single));

endmodule

// File: tb/secded_seq_bench.sv
// Bench for secded_seq with default parameters (6 states, 7-bit word).
// Random advance, upset and clear stimulus from a fixed seed, plus directed
// cases; every output is compared against a bench model at each falling edge.
module secded_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       advance;
    logic       clear_err;
    logic [6:0] inj;
    logic [5:0] strobe;
    logic       corr;
    logic       uncorr;
    logic       halted;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model: state, halt, flag, pulse, pending error (0 none, 1 single, 2 double, 3 illegal).
    int ms, mh, mf, mc, pend;

    always #5 clk = ~clk;

    secded_seq u_secded_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .advance_i       (advance),
        .clear_err_i     (clear_err),
        .inject_mask_i   (inj),
        .state_strobe_o  (strobe),
        .corrected_o     (corr),
        .uncorrectable_o (uncorr),
        .halted_o        (halted)
    );

    // Extended Hamming encoding of a state code, as laid out in R1.
    function automatic logic [6:0] enc(input logic [2:0] s);
        logic [6:0] w;
        w[3] = s[0]; w[5] = s[1]; w[6] = s[2];
        w[1] = s[0] ^ s[1];
        w[2] = s[0] ^ s[2];
        w[4] = s[1] ^ s[2];
        w[0] = ^w[6:1];
        return w;
    endfunction

    function automatic logic [5:0] exp_strobe();
        if (mh != 0 || pend >= 2) return 6'd0;
        return 6'(1 << ms);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " R6 strobes"}, int'(strobe), int'(exp_strobe()));
        check({tag, " R4 corrected"}, int'(corr), mc);
        check({tag, " R7 uncorrectable"}, int'(uncorr), mf);
        check({tag, " R7 halted"}, int'(halted), mh);
    endtask

    // Drive one cycle (caller is at a falling edge), update the model, compare.
    task automatic step(input bit adv, input bit clr, input logic [6:0] mask, input string tag);
        int wt;
        advance = adv; clear_err = clr; inj = mask;
        @(posedge clk);
        wt = $countones(mask);
        if (clr) begin
            ms = 0; mh = 0; mf = 0; mc = 0; pend = 0;
        end else if (mask != 0) begin
            mc = 0;
            if (wt == 1) pend = 1;
            else if (wt == 2) pend = 2;
            else pend = 3;
        end else if (mh != 0) begin
            mc = 0;
        end else if (pend >= 2) begin
            mh = 1; mf = 1; mc = 0;
        end else begin
            mc = (pend == 1) ? 1 : 0;
            pend = 0;
            if (adv) ms = (ms == 5) ? 0 : ms + 1;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; advance = 1'b0; clear_err = 1'b0; inj = '0;
        ms = 0; mh = 0; mf = 0; mc = 0; pend = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R2: reset state.
        check("R2 strobe0", int'(strobe), 1);
        check("R2 flags", int'({corr, uncorr, halted}), 0);
        rst_n = 1'b1;

        // R5: a full lap with wrap, then a hold.
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, '0, "R5 lap");
        step(1'b0, 1'b0, '0, "R5 hold");

        // R10: an injection edge does not advance; R3: the repair keeps the sequence.
        step(1'b1, 1'b0, 7'b0001000, "R10 inject");
        check("R10 no advance", int'(strobe), int'(6'(1 << ms)));
        step(1'b1, 1'b0, '0, "R3 repair");
        check("R4 pulse", int'(corr), 1);
        step(1'b1, 1'b0, '0, "R4 after");
        check("R4 one cycle", int'(corr), 0);

        // R1 and R8: move the word onto the codeword of state 6.
        step(1'b0, 1'b0, enc(3'(ms)) ^ enc(3'd6), "R1 illegal inject");
        check("R1 no strobe on code 6", int'(strobe), 0);
        step(1'b1, 1'b0, '0, "R8 halt");
        check("R8 halted", int'(halted), 1);
        step(1'b1, 1'b0, '0, "R7 sticky");
        // R9: clear returns to 0.
        step(1'b0, 1'b1, '0, "R9 clear");
        check("R9 state0", int'(strobe), 1);

        // R7: double upset on the parity bit and a state bit.
        step(1'b0, 1'b0, 7'b0100001, "R7 double inject");
        step(1'b1, 1'b0, '0, "R7 halt");
        check("R7 flag", int'(uncorr), 1);
        step(1'b0, 1'b1, '0, "R9 clear2");

        // Random mix of advance, upsets and clears.
        for (int n = 0; n < 3000; n++) begin
            bit adv;
            bit clr;
            logic [6:0] m;
            int r;
            adv = ($urandom % 4) != 0;
            clr = 1'b0;
            m = '0;
            r = int'($urandom % 100);
            if (mh != 0) begin
                clr = (r < 25);
            end else if (pend == 0) begin
                if (r < 8) begin
                    m = 7'(1 << ($urandom % 7));
                end else if (r < 11) begin
                    int a;
                    int b;
                    a = int'($urandom % 7);
                    b = (a + 1 + int'($urandom % 6)) % 7;
                    m = 7'((1 << a) | (1 << b));
                end else if (r < 12) begin
                    m = enc(3'(ms)) ^ enc(($urandom % 2) != 0 ? 3'd7 : 3'd6);
                end else if (r < 13) begin
                    clr = 1'b1;
                end
            end
            step(adv, clr, m, "R3 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule